// File: doc/BRIEF.md
# Embedded Controller Host Port

This block is the device side of a two-port host interface to a small embedded controller. A host on an 8-bit I/O bus sees a data port and a shared port that reads back as status and accepts commands when written. Every access to the controller's 256-byte register space is a short exchange of bytes. The host writes a command byte to the command port, writes an address byte to the data port, and for a write it then sends a data byte. For a read it collects the result from the data port.

Two handshake flags pace the exchange. The input-full flag tells the host that its last byte has not yet been taken. The output-full flag tells the host that a result byte is waiting. A third flag records whether the last byte written went to the command port. The block turns each completed exchange into a single-cycle strobe on an internal byte-wide register bus. Read data comes back one cycle after the read strobe. Burst enable and disable only toggle a status flag. A query always answers that no event is pending.

Top module: `ec_host_port`

## Requirements
- R1: After reset the status port (host_sel=1) reads 0x00 and the data port (host_sel=0) reads 0x00. The status layout is: bit 0 output-full, bit 1 input-full, bit 3 last-write-was-command, bit 4 burst; bits 2, 5, 6 and 7 read 0.
- R2: A host write to either port sets input-full in the next cycle. When the block is waiting for a byte it clears the flag one cycle later.
- R3: A write to the command port sets the last-write-was-command flag and a write to the data port clears it. The flag takes its new value in the same cycle in which input-full rises.
- R4: Command 0x80 followed by an address byte issues one reg_rd pulse carrying that address. The returned byte is placed in the data register, and output-full is set two cycles after the address byte is captured.
- R5: A host read of the data port clears output-full in the next cycle.
- R6: Command 0x81 followed by an address byte and then a data byte issues exactly one single-cycle reg_wr pulse carrying that address and data. reg_wr and reg_rd are never active together.
- R7: Command 0x82 sets the burst flag and command 0x83 clears it, one cycle after the command byte is captured.
- R8: Command 0x84 loads 0x00 into the data register and sets output-full.
- R9: Any other command byte is discarded, input-full is cleared and the block returns to idle. Data bytes that follow cause no register access.
- R10: A data byte that arrives while no command is open is discarded. It causes no register access and leaves output-full unchanged.
- R11: A command byte that arrives in the middle of a read or write sequence abandons that sequence and starts the new one. The abandoned sequence neither writes a register nor sets output-full.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| host_sel | input | 1 | Port select: 1 = status/command port, 0 = data port |
| host_wr | input | 1 | Single-cycle host write strobe |
| host_rd | input | 1 | Single-cycle host read strobe |
| host_wdata | input | 8 | Byte written by the host |
| host_rdata | output | 8 | Status byte or data register, chosen by host_sel |
| reg_addr | output | 8 | Register-bus address |
| reg_wr | output | 1 | Register-bus write strobe |
| reg_wdata | output | 8 | Register-bus write data |
| reg_rd | output | 1 | Register-bus read strobe |
| reg_rdata | input | 8 | Register-bus read data, valid the cycle after reg_rd |

## Verification
The assertions assume a well-behaved host. It never writes while input-full is set. Its write and read strobes last exactly one cycle. The register space answers a read strobe in the following cycle. Under these assumptions input-full can never stay high for more than one cycle, and the flag timings are fixed enough to check cycle by cycle. The bench host polls the status port until input-full is clear before every byte and polls output-full before every read. The bench register model returns data one cycle after each read strobe, so random and directed traffic both stay inside these assumptions.

// File: rtl/ec_pkg.sv
package ec_pkg;

  localparam logic [7:0] CMD_READ    = 8'h80;
  localparam logic [7:0] CMD_WRITE   = 8'h81;
  localparam logic [7:0] CMD_BURST_E = 8'h82;
  localparam logic [7:0] CMD_BURST_D = 8'h83;
  localparam logic [7:0] CMD_QUERY   = 8'h84;

  localparam int ST_OUT_FULL = 0;
  localparam int ST_IN_FULL  = 1;
  localparam int ST_CMD_LAST = 3;
  localparam int ST_BURST    = 4;

  typedef enum logic [2:0] {
    SQ_IDLE    = 3'd0,
    SQ_RD_ADDR = 3'd1,
    SQ_RD_WAIT = 3'd2,
    SQ_WR_ADDR = 3'd3,
    SQ_WR_DATA = 3'd4
  } seq_state_e;

endpackage

// File: rtl/ec_rst_sync.sv
module ec_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/ec_in_latch.sv
module ec_in_latch #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic          sel,
  input  logic [DW-1:0] wdata,
  input  logic          consume,
  output logic [DW-1:0] in_byte,
  output logic          in_cmd,
  output logic          ibf
);
  logic          ibf_d;
  logic          ibf_q;
  logic [DW-1:0] byte_q;
  logic          cmd_q;

  always_comb begin
    ibf_d = ibf_q;
    if (consume) ibf_d = 1'b0;
    if (wr)      ibf_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ibf_q  <= 1'b0;
      byte_q <= '0;
      cmd_q  <= 1'b0;
    end else begin
      ibf_q <= ibf_d;
      if (wr) begin
        byte_q <= wdata;
        cmd_q  <= sel;
      end
    end
  end

  assign in_byte = byte_q;
  assign in_cmd  = cmd_q;
  assign ibf     = ibf_q;
endmodule

// File: rtl/ec_out_buf.sv
module ec_out_buf #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [DW-1:0] load_data,
  input  logic          host_take,
  output logic [DW-1:0] data_out,
  output logic          obf
);
  logic          obf_d;
  logic          obf_q;
  logic [DW-1:0] data_q;

  always_comb begin
    obf_d = obf_q;
    if (host_take) obf_d = 1'b0;
    if (load)      obf_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      obf_q  <= 1'b0;
      data_q <= '0;
    end else begin
      obf_q <= obf_d;
      if (load) data_q <= load_data;
    end
  end

  assign data_out = data_q;
  assign obf      = obf_q;
endmodule

// File: rtl/ec_seq.sv
module ec_seq
  import ec_pkg::*;
#(
  parameter int DW = 8,
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ibf,
  input  logic [DW-1:0] in_byte,
  input  logic          in_cmd,
  output logic          consume,
  output logic [AW-1:0] reg_addr,
  output logic          reg_wr,
  output logic [DW-1:0] reg_wdata,
  output logic          reg_rd,
  input  logic [DW-1:0] reg_rdata,
  output logic          ob_load,
  output logic [DW-1:0] ob_data,
  output logic          burst
);
  seq_state_e    state_q, state_d;
  logic [AW-1:0] addr_q, addr_d;
  logic          burst_q, burst_d;
  logic          addr_en;

  always_comb begin
    state_d   = state_q;
    addr_d    = addr_q;
    addr_en   = 1'b0;
    burst_d   = burst_q;
    consume   = 1'b0;
    reg_addr  = addr_q;
    reg_wr    = 1'b0;
    reg_wdata = in_byte;
    reg_rd    = 1'b0;
    ob_load   = 1'b0;
    ob_data   = '0;
    if (state_q == SQ_RD_WAIT) begin
      ob_load = 1'b1;
      ob_data = reg_rdata;
      state_d = SQ_IDLE;
    end else if (ibf) begin
      consume = 1'b1;
      if (in_cmd) begin
        state_d = SQ_IDLE;
        if (in_byte == DW'(CMD_READ))         state_d = SQ_RD_ADDR;
        else if (in_byte == DW'(CMD_WRITE))   state_d = SQ_WR_ADDR;
        else if (in_byte == DW'(CMD_BURST_E)) burst_d = 1'b1;
        else if (in_byte == DW'(CMD_BURST_D)) burst_d = 1'b0;
        else if (in_byte == DW'(CMD_QUERY))   ob_load = 1'b1;
      end else begin
        case (state_q)
          SQ_RD_ADDR: begin
            reg_rd   = 1'b1;
            reg_addr = AW'(in_byte);
            state_d  = SQ_RD_WAIT;
          end
          SQ_WR_ADDR: begin
            addr_d  = AW'(in_byte);
            addr_en = 1'b1;
            state_d = SQ_WR_DATA;
          end
          SQ_WR_DATA: begin
            reg_wr  = 1'b1;
            state_d = SQ_IDLE;
          end
          default: state_d = SQ_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SQ_IDLE;
      addr_q  <= '0;
      burst_q <= 1'b0;
    end else begin
      state_q <= state_d;
      burst_q <= burst_d;
      if (addr_en) addr_q <= addr_d;
    end
  end

  assign burst = burst_q;
endmodule

// File: rtl/ec_host_port.sv
module ec_host_port
  import ec_pkg::*;
#(
  parameter int DW = 8,
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          host_sel,
  input  logic          host_wr,
  input  logic          host_rd,
  input  logic [DW-1:0] host_wdata,
  output logic [DW-1:0] host_rdata,
  output logic [AW-1:0] reg_addr,
  output logic          reg_wr,
  output logic [DW-1:0] reg_wdata,
  output logic          reg_rd,
  input  logic [DW-1:0] reg_rdata
);
  logic          rst_sync_n;
  logic          ibf;
  logic          obf;
  logic          in_cmd;
  logic          burst_q;
  logic          consume;
  logic          ob_load;
  logic [DW-1:0] in_byte;
  logic [DW-1:0] ob_data;
  logic [DW-1:0] data_reg;
  logic [DW-1:0] status;

  ec_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  ec_in_latch #(.DW(DW)) u_in (
    .clk(clk), .rst_n(rst_sync_n), .wr(host_wr), .sel(host_sel),
    .wdata(host_wdata), .consume(consume), .in_byte(in_byte),
    .in_cmd(in_cmd), .ibf(ibf)
  );

  ec_seq #(.DW(DW), .AW(AW)) u_seq (
    .clk(clk), .rst_n(rst_sync_n), .ibf(ibf), .in_byte(in_byte),
    .in_cmd(in_cmd), .consume(consume), .reg_addr(reg_addr),
    .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rd(reg_rd),
    .reg_rdata(reg_rdata), .ob_load(ob_load), .ob_data(ob_data),
    .burst(burst_q)
  );

  ec_out_buf #(.DW(DW)) u_out (
    .clk(clk), .rst_n(rst_sync_n), .load(ob_load), .load_data(ob_data),
    .host_take(host_rd && !host_sel), .data_out(data_reg), .obf(obf)
  );

  always_comb begin
    status              = '0;
    status[ST_OUT_FULL] = obf;
    status[ST_IN_FULL]  = ibf;
    status[ST_CMD_LAST] = in_cmd;
    status[ST_BURST]    = burst_q;
  end

  assign host_rdata = host_sel ? status : data_reg;
endmodule

// File: rtl/ec_host_port_chk.sv
module ec_host_port_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          host_sel,
  input logic          host_wr,
  input logic          host_rd,
  input logic [DW-1:0] host_wdata,
  input logic          ibf,
  input logic          obf,
  input logic          in_cmd,
  input logic          burst_q,
  input logic          ob_load,
  input logic          reg_wr,
  input logic          reg_rd
);
  assert_ibf_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
    host_wr |=> ibf);

  assert_ibf_drain_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ibf && !host_wr |=> !ibf);

  assert_cmd_mark_R3: assert property (@(posedge clk) disable iff (!rst_n)
    host_wr && host_sel |=> in_cmd);

  assert_data_mark_R3: assert property (@(posedge clk) disable iff (!rst_n)
    host_wr && !host_sel |=> !in_cmd);

  assert_read_result_R4: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd |-> ##2 obf);

  assert_take_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
    host_rd && !host_sel && !ob_load |=> !obf);

  assert_wr_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |=> !reg_wr);

  assert_bus_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({reg_wr, reg_rd}) <= 1);

  assert_burst_on_R7: assert property (@(posedge clk) disable iff (!rst_n)
    host_wr && host_sel && host_wdata == DW'(8'h82) |-> ##2 burst_q);

  assert_burst_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
    host_wr && host_sel && host_wdata == DW'(8'h83) |-> ##2 !burst_q);
endmodule

bind ec_host_port ec_host_port_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .host_sel(host_sel), .host_wr(host_wr),
  .host_rd(host_rd), .host_wdata(host_wdata), .ibf(ibf), .obf(obf),
  .in_cmd(in_cmd), .burst_q(burst_q), .ob_load(ob_load),
  .reg_wr(reg_wr), .reg_rd(reg_rd)
);

// File: tb/ec_host_port_tb.sv
module ec_host_port_tb;
  logic       clk;
  logic       rst_n;
  logic       host_sel;
  logic       host_wr;
  logic       host_rd;
  logic [7:0] host_wdata;
  logic [7:0] host_rdata;
  logic [7:0] reg_addr;
  logic       reg_wr;
  logic [7:0] reg_wdata;
  logic       reg_rd;
  logic [7:0] reg_rdata;

  logic [7:0] mem [256];
  logic [7:0] exp_mem [256];
  int n_chk;
  int n_fail;

  ec_host_port u_dut (
    .clk(clk), .rst_n(rst_n), .host_sel(host_sel), .host_wr(host_wr),
    .host_rd(host_rd), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rd(reg_rd), .reg_rdata(reg_rdata)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic logic [7:0] seed_val(input int i);
    return 8'(i * 37 + 5);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) mem[i] <= seed_val(i);
      reg_rdata <= 8'h00;
    end else begin
      if (reg_wr) mem[reg_addr] <= reg_wdata;
      if (reg_rd) reg_rdata <= mem[reg_addr];
    end
  end

  task automatic chk(input logic ok, input string req, input logic [7:0] act,
                     input logic [7:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic get_status(output logic [7:0] st);
    host_sel = 1'b1;
    #1;
    st = host_rdata;
  endtask

  task automatic host_put(input logic sel, input logic [7:0] b);
    logic [7:0] st;
    int n;
    n = 0;
    get_status(st);
    while (st[1] && n < 50) begin
      @(negedge clk);
      get_status(st);
      n++;
    end
    if (n >= 50) chk(1'b0, "R2 input-full stuck", st, 8'h00);
    host_sel   = sel;
    host_wdata = b;
    host_wr    = 1'b1;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic host_get(output logic [7:0] b);
    logic [7:0] st;
    int n;
    n = 0;
    get_status(st);
    while (!st[0] && n < 20) begin
      @(negedge clk);
      get_status(st);
      n++;
    end
    if (n >= 20) chk(1'b0, "R4 output-full never set", st, 8'h01);
    host_sel = 1'b0;
    host_rd  = 1'b1;
    #1;
    b = host_rdata;
    @(negedge clk);
    host_rd = 1'b0;
  endtask

  task automatic ec_read(input logic [7:0] a, output logic [7:0] b);
    host_put(1'b1, 8'h80);
    host_put(1'b0, a);
    host_get(b);
  endtask

  task automatic ec_write(input logic [7:0] a, input logic [7:0] d);
    host_put(1'b1, 8'h81);
    host_put(1'b0, a);
    host_put(1'b0, d);
    exp_mem[a] = d;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=00 expected=00");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [7:0] st;
    logic [7:0] b;
    n_chk = 0;
    n_fail = 0;
    host_sel = 1'b1; host_wr = 1'b0; host_rd = 1'b0; host_wdata = 8'h00;
    for (int i = 0; i < 256; i++) exp_mem[i] = seed_val(i);
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state of both ports
    get_status(st);
    chk(st == 8'h00, "R1 status after reset", st, 8'h00);
    host_sel = 1'b0; #1;
    chk(host_rdata == 8'h00, "R1 data after reset", host_rdata, 8'h00);

    // R2, R3, R7: burst enable command
    host_put(1'b1, 8'h82);
    get_status(st);
    chk(st == 8'h0A, "R2 R3 input-full and command mark", st, 8'h0A);
    @(negedge clk); get_status(st);
    chk(st == 8'h18, "R2 R7 consumed, burst on", st, 8'h18);
    host_put(1'b1, 8'h83);
    @(negedge clk); get_status(st);
    chk(st == 8'h08, "R7 burst off", st, 8'h08);

    // R3, R10: stray data byte in idle
    host_put(1'b0, 8'h5A);
    get_status(st);
    chk(st == 8'h02, "R3 data clears command mark", st, 8'h02);
    @(negedge clk); get_status(st);
    chk(st == 8'h00, "R10 stray byte leaves output-full clear", st, 8'h00);

    // R8, R5: query
    host_put(1'b1, 8'h84);
    host_get(b);
    chk(b == 8'h00, "R8 query result", b, 8'h00);
    get_status(st);
    chk(st[0] == 1'b0, "R5 data read clears output-full", st, 8'h08);

    // R4: read timing
    host_put(1'b1, 8'h80);
    host_put(1'b0, 8'h10);
    @(negedge clk); get_status(st);
    chk(st[0] == 1'b0, "R4 output-full not yet", st, 8'h00);
    @(negedge clk); get_status(st);
    chk(st[0] == 1'b1, "R4 output-full two cycles after address", st, 8'h01);
    host_get(b);
    chk(b == exp_mem[8'h10], "R4 read data", b, exp_mem[8'h10]);

    // R10: stray byte made no register access
    ec_read(8'h5A, b);
    chk(b == exp_mem[8'h5A], "R10 no write from stray byte", b, exp_mem[8'h5A]);

    // R6: write then read back
    ec_write(8'h20, 8'hC3);
    ec_read(8'h20, b);
    chk(b == 8'hC3, "R6 write readback", b, 8'hC3);

    // R9: unknown command aborts a write, trailing data ignored
    host_put(1'b1, 8'h81);
    host_put(1'b0, 8'h30);
    host_put(1'b1, 8'h55);
    @(negedge clk); get_status(st);
    chk(st == 8'h08, "R9 unknown command discarded", st, 8'h08);
    host_put(1'b0, 8'h99);
    @(negedge clk);
    ec_read(8'h30, b);
    chk(b == exp_mem[8'h30], "R9 no write after unknown command", b, exp_mem[8'h30]);

    // R11: read abandoned by write command
    host_put(1'b1, 8'h80);
    host_put(1'b1, 8'h81);
    host_put(1'b0, 8'h40);
    host_put(1'b0, 8'h77);
    exp_mem[8'h40] = 8'h77;
    repeat (3) @(negedge clk);
    get_status(st);
    chk(st[0] == 1'b0, "R11 abandoned read sets no output-full", st, 8'h00);
    ec_read(8'h40, b);
    chk(b == 8'h77, "R11 new write took effect", b, 8'h77);

    // R11: write abandoned by read command
    host_put(1'b1, 8'h81);
    host_put(1'b0, 8'h50);
    host_put(1'b1, 8'h80);
    host_put(1'b0, 8'h51);
    host_get(b);
    chk(b == exp_mem[8'h51], "R11 new read result", b, exp_mem[8'h51]);
    ec_read(8'h50, b);
    chk(b == exp_mem[8'h50], "R11 abandoned write left register", b, exp_mem[8'h50]);

    // Random mixed traffic, R4 and R6
    void'($urandom(32'd2024));
    for (int k = 0; k < 300; k++) begin
      logic [7:0] a;
      logic [7:0] d;
      a = 8'($urandom);
      d = 8'($urandom);
      if ($urandom % 2 == 0) begin
        ec_write(a, d);
      end else begin
        ec_read(a, b);
        chk(b == exp_mem[a], "R4 R6 random read", b, exp_mem[a]);
      end
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule